// File: doc/BRIEF.md
# Two-Slot Frame Transmit Buffer

This block sits between a processor bus and a byte-wide transmit path. It holds two frame slots, called ping and pong. Each slot has its own word-addressed buffer RAM, a byte-count register and a control/status register. Software fills a slot that is not busy, writes the byte count, and then sets the busy bit. The block then streams the frame out one byte per accepted handshake and clears busy when it is done. If the interrupt enable of that slot is set, the block also raises a one-cycle interrupt pulse.

A second command reuses the same slot to load the station address. Setting busy and program together makes the block copy the first six buffer bytes into a 48-bit station-address register instead of sending them. The pong slot is present only when the parameter `PONG_EN` is 1. With both slots in use, the slot that was launched first is served first. Preamble, checksum and line signalling belong to later stages.

Top module: `txpp_top`

## Requirements
- R1: After reset, every status and count register reads 0, `tx_valid` and `tx_irq` are low, and `mac_addr` is 0.
- R2: Address bit 11 selects the slot (0 ping, 1 pong). Within a slot, offset 0x7F4 is the byte count in bits 15:0 (upper bits ignored on write, read as 0). Offset 0x7FC is the status register. Offsets below `BUF_WORDS*4` write buffer word offset/4. Any other offset reads 0.
- R3: The status register has busy in bit 0, program in bit 1 and interrupt enable in bit 3, and reads back in those positions. A write with bit 0 set to a slot that is not busy launches that slot.
- R4: A frame leaves in buffer order, with bits 31:24 of each word sent first and bits 7:0 last.
- R5: Exactly min(count, `BUF_WORDS*4`) bytes are sent. Busy reads 0 once the last byte has been accepted.
- R6: A count of 0 sends no byte and still completes (busy clears).
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds. `tx_last` is high with the final byte only.
- R8: A status write with bits 0 and 1 both set sends no bytes and raises no interrupt. It loads `mac_addr` with the first six buffer bytes (byte 0 in bits 47:40), then clears both bits.
- R9: A status write with bit 0 clear stops the slot. Busy and program clear, no further byte of that frame is offered, and no interrupt is raised.
- R10: When both slots are pending, the one whose busy bit was set first is sent first.
- R11: Each completed send of a slot with bit 3 set gives exactly one single-cycle `tx_irq` pulse. Sends with bit 3 clear give none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register/buffer window |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | `tx_data` holds a byte |
| tx_ready | input | 1 | Downstream accepts the byte this cycle |
| tx_last | output | 1 | Current byte is the last of its frame |
| tx_irq | output | 1 | One-cycle send-complete pulse |
| mac_addr | output | 48 | Station address loaded by the program command |

## Verification
A wrong byte index or slot choice appears on `tx_data` within the same frame: a swapped lane or a frame from the other slot shows on the first mismatched byte. A count register that is off by one shows as one byte too many or too few, and as `tx_last` in the wrong place. Stuck busy or ordering state shows at the status register one poll after the last byte, or as the wrong frame leading when two slots are pending. A lost abort shows as bytes or an interrupt pulse after the clearing write.

// File: rtl/txpp_pkg.sv
package txpp_pkg;
  localparam int unsigned ADDR_W   = 12;
  localparam int unsigned OFS_W    = 11;
  localparam logic [10:0] OFS_LEN  = 11'h7F4;
  localparam logic [10:0] OFS_STAT = 11'h7FC;
  localparam int unsigned ST_BUSY  = 0;
  localparam int unsigned ST_PROG  = 1;
  localparam int unsigned ST_IE    = 3;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_SEND = 2'd1,
    ENG_LOAD = 2'd2
  } eng_state_t;
endpackage

// File: rtl/txpp_slot.sv
module txpp_slot
  import txpp_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 64,
  localparam int unsigned WIDX_W   = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [31:0]       wdata_i,
  input  logic              done_i,
  input  logic [WIDX_W-1:0] rd_idx_i,
  output logic [31:0]       rd_word_o,
  output logic [31:0]       rdata_o,
  output logic              busy_o,
  output logic              prog_o,
  output logic              ie_o,
  output logic              launch_o,
  output logic [15:0]       len_o
);
  localparam logic [OFS_W-1:0] BUF_LIMIT = OFS_W'(BUF_WORDS * 4);

  logic [31:0] mem_q [BUF_WORDS];
  logic        busy_q, busy_d, prog_q, prog_d, ie_q, ie_d;
  logic [15:0] len_q, len_d;
  logic        stat_wr, len_wr, buf_wr;

  assign stat_wr  = sel_i && wr_i && (ofs_i == OFS_STAT);
  assign len_wr   = sel_i && wr_i && (ofs_i == OFS_LEN);
  assign buf_wr   = sel_i && wr_i && (ofs_i < BUF_LIMIT);
  assign launch_o = stat_wr && wdata_i[ST_BUSY] && !busy_q;

  always_comb begin
    busy_d = busy_q;
    prog_d = prog_q;
    ie_d   = ie_q;
    len_d  = len_q;
    if (done_i) begin
      busy_d = 1'b0;
      prog_d = 1'b0;
    end
    if (len_wr) len_d = wdata_i[15:0];
    if (stat_wr) begin
      ie_d = wdata_i[ST_IE];
      if (!wdata_i[ST_BUSY]) begin
        busy_d = 1'b0;
        prog_d = 1'b0;
      end else if (!busy_q) begin
        busy_d = 1'b1;
        prog_d = wdata_i[ST_PROG];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      prog_q <= 1'b0;
      ie_q   <= 1'b0;
      len_q  <= '0;
    end else begin
      busy_q <= busy_d;
      prog_q <= prog_d;
      ie_q   <= ie_d;
      len_q  <= len_d;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_wr) mem_q[ofs_i[WIDX_W+1:2]] <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i && ofs_i == OFS_STAT) rdata_o = {28'd0, ie_q, 1'b0, prog_q, busy_q};
    else if (sel_i && ofs_i == OFS_LEN) rdata_o = {16'd0, len_q};
  end

  assign rd_word_o = mem_q[rd_idx_i];
  assign busy_o    = busy_q;
  assign prog_o    = prog_q;
  assign ie_o      = ie_q;
  assign len_o     = len_q;

  // R8
  prog_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_q |-> busy_q);
  // R9
  busy_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done_i || stat_wr));
endmodule

// File: rtl/txpp_engine.sv
module txpp_engine
  import txpp_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 64,
  localparam int unsigned WIDX_W   = $clog2(BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        busy_i,
  input  logic [1:0]        prog_i,
  input  logic [1:0]        ie_i,
  input  logic [1:0]        launch_i,
  input  logic [1:0][15:0]  len_i,
  input  logic [1:0][31:0]  word_i,
  input  logic              tx_ready_i,
  output logic [WIDX_W-1:0] rd_idx_o,
  output logic [1:0]        done_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  output logic              irq_o,
  output logic [47:0]       mac_o
);
  localparam logic [15:0] CAP = 16'(BUF_WORDS * 4);

  eng_state_t  st_q, st_d;
  logic        cur_q, cur_d, older_q, older_d, irq_q, irq_d, pick;
  logic [15:0] idx_q, idx_d, cnt_q, cnt_d;
  logic [47:0] mac_q, mac_d;
  logic [31:0] word;

  assign word  = word_i[cur_q];
  assign pick  = (busy_i == 2'b11) ? older_q : busy_i[1];

  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    mac_d   = mac_q;
    older_d = older_q;
    irq_d   = 1'b0;
    done_o  = 2'b00;
    if (launch_i[0]) older_d = busy_i[1];
    if (launch_i[1]) older_d = !busy_i[0];
    case (st_q)
      ENG_IDLE: if (|busy_i) begin
        cur_d = pick;
        idx_d = '0;
        cnt_d = (len_i[pick] > CAP) ? CAP : len_i[pick];
        st_d  = prog_i[pick] ? ENG_LOAD : ENG_SEND;
      end
      ENG_SEND: begin
        if (!busy_i[cur_q]) st_d = ENG_IDLE;
        else if (idx_q == cnt_q) begin
          done_o[cur_q] = 1'b1;
          irq_d         = ie_i[cur_q];
          st_d          = ENG_IDLE;
        end else if (tx_ready_i) idx_d = idx_q + 16'd1;
      end
      ENG_LOAD: begin
        if (!busy_i[cur_q]) st_d = ENG_IDLE;
        else if (idx_q == 16'd0) begin
          mac_d[47:16] = word;
          idx_d        = 16'd4;
        end else begin
          mac_d[15:0]   = word[31:16];
          done_o[cur_q] = 1'b1;
          st_d          = ENG_IDLE;
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      cur_q   <= 1'b0;
      older_q <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
      mac_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      older_q <= older_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      mac_q   <= mac_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    case (idx_q[1:0])
      2'd0:    tx_data_o = word[31:24];
      2'd1:    tx_data_o = word[23:16];
      2'd2:    tx_data_o = word[15:8];
      default: tx_data_o = word[7:0];
    endcase
  end

  assign rd_idx_o   = idx_q[WIDX_W+1:2];
  assign tx_valid_o = (st_q == ENG_SEND) && busy_i[cur_q] && (idx_q != cnt_q);
  assign tx_last_o  = tx_valid_o && (idx_q == cnt_q - 16'd1);
  assign irq_o      = irq_q;
  assign mac_o      = mac_q;

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o && !tx_ready_i |=> !tx_valid_o || $stable(tx_data_o));
  // R5
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_SEND) |-> (idx_q <= cnt_q) && (cnt_q <= CAP));
  // R8
  mac_only_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_q != $past(mac_q)) |-> ($past(st_q) == ENG_LOAD));
  // R11
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R10
  one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o));
endmodule

// File: rtl/txpp_top.sv
module txpp_top
  import txpp_pkg::*;
#(
  parameter int unsigned BUF_WORDS = 64,
  parameter bit          PONG_EN   = 1'b1,
  localparam int unsigned WIDX_W   = $clog2(BUF_WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        tx_last,
  output logic        tx_irq,
  output logic [47:0] mac_addr
);
  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic [1:0]        busy, prog, ie, launch, done;
  logic [1:0][15:0]  len;
  logic [1:0][31:0]  word, rdata;
  logic [WIDX_W-1:0] rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  for (genvar g = 0; g < 2; g++) begin : g_slot
    if (g == 0 || PONG_EN) begin : g_on
      txpp_slot #(.BUF_WORDS(BUF_WORDS)) u_slot (
        .clk(clk), .rst_n(rst_ni),
        .sel_i(bus_addr[ADDR_W-1] == 1'(g)), .wr_i(bus_wr),
        .ofs_i(bus_addr[OFS_W-1:0]), .wdata_i(bus_wdata),
        .done_i(done[g]), .rd_idx_i(rd_idx),
        .rd_word_o(word[g]), .rdata_o(rdata[g]),
        .busy_o(busy[g]), .prog_o(prog[g]), .ie_o(ie[g]),
        .launch_o(launch[g]), .len_o(len[g])
      );
    end else begin : g_off
      assign word[g]   = '0;
      assign rdata[g]  = '0;
      assign busy[g]   = 1'b0;
      assign prog[g]   = 1'b0;
      assign ie[g]     = 1'b0;
      assign launch[g] = 1'b0;
      assign len[g]    = '0;
    end
  end

  assign bus_rdata = rdata[0] | rdata[1];

  txpp_engine #(.BUF_WORDS(BUF_WORDS)) u_engine (
    .clk(clk), .rst_n(rst_ni),
    .busy_i(busy), .prog_i(prog), .ie_i(ie), .launch_i(launch),
    .len_i(len), .word_i(word), .tx_ready_i(tx_ready),
    .rd_idx_o(rd_idx), .done_o(done),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_last_o(tx_last),
    .irq_o(tx_irq), .mac_o(mac_addr)
  );

  // R9
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy == 2'b00) |-> !tx_valid);
endmodule

// File: tb/txpp_top_tb.sv
module txpp_top_tb;
  localparam int BW  = 64;
  localparam int CAP = BW * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready, tx_last, tx_irq;
  logic [47:0] mac_addr;

  txpp_top #(.BUF_WORDS(BW), .PONG_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last),
    .tx_irq(tx_irq), .mac_addr(mac_addr)
  );

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int rdy_mode = 0;
  int cap_n = 0, irq_n = 0, hold_err = 0;
  logic [7:0] cap [0:2*CAP+7];
  logic       cap_last [0:2*CAP+7];
  logic [7:0] fb [0:1][0:CAP-1];
  logic       pv = 1'b0, pr = 1'b0;
  logic [7:0] pd = '0;

  initial tx_ready = 1'b0;

  always @(negedge clk) begin
    if (pv && !pr && tx_valid && tx_data != pd) hold_err++;
    case (rdy_mode)
      0: tx_ready = 1'b0;
      1: tx_ready = ($urandom % 3) != 0;
      default: tx_ready = 1'b1;
    endcase
    if (tx_valid && tx_ready) begin
      cap[cap_n] = tx_data;
      cap_last[cap_n] = tx_last;
      cap_n++;
    end
    if (tx_irq) irq_n++;
    pv = tx_valid; pr = tx_ready; pd = tx_data;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the next one
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [11:0] base(input int s);
    return s != 0 ? 12'h800 : 12'h000;
  endfunction

  function automatic int eff_len(input int len);
    return len > CAP ? CAP : len;
  endfunction

  task automatic load(input int s, input int len);
    int n = eff_len(len);
    for (int i = 0; i < CAP; i++) fb[s][i] = 8'($urandom);
    for (int w = 0; w < (n + 3) / 4 || w < 2; w++)
      wr(base(s) + 12'(w * 4), {fb[s][4*w], fb[s][4*w+1], fb[s][4*w+2], fb[s][4*w+3]});
    wr(base(s) + 12'h7F4, 32'(len));
  endtask

  task automatic wait_free(input int s, input string tag);
    logic [31:0] v;
    int k = 0;
    rd(base(s) + 12'h7FC, v);
    while (v[0] && k < 5000) begin
      @(negedge clk); k++;
      rd(base(s) + 12'h7FC, v);
    end
    repeat (3) @(negedge clk);
    chk(v[1:0] == 2'b00, tag, v[1:0], 0);
  endtask

  task automatic cmp_frame(input int s, input int start, input int n, input string tag);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      if (cap[start + k] !== fb[s][k]) bad++;
      if (cap_last[start + k] !== (k == n - 1)) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  initial begin
    logic [31:0] v;
    int ok;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(12'h7FC, v); chk(v == 0, "R1 ping status", v, 0);
    rd(12'hFFC, v); chk(v == 0, "R1 pong status", v, 0);
    rd(12'h7F4, v); chk(v == 0, "R1 ping count", v, 0);
    chk(!tx_valid && !tx_irq, "R1 valid/irq", {tx_valid, tx_irq}, 0);
    chk(mac_addr == 0, "R1 mac", mac_addr, 0);

    // R2 map and count width, R3 status bit positions
    wr(12'hFF4, 32'hABCD_5678);
    rd(12'hFF4, v); chk(v == 32'h5678, "R2 count 16 bits", v, 32'h5678);
    rd(12'h7F4, v); chk(v == 0, "R2 slot select", v, 0);
    rd(12'h7F8, v); chk(v == 0, "R2 unmapped reads 0", v, 0);
    wr(12'h7FC, 32'h8);
    rd(12'h7FC, v); chk(v == 32'h8, "R3 ie readback", v, 8);
    chk(!tx_valid, "R3 no launch without bit0", tx_valid, 0);

    // R4 R5 R7 R11 random frames
    rdy_mode = 1;
    for (int t = 0; t < 8; t++) begin
      int s = $urandom % 2;
      int len = 1 + ($urandom % CAP);
      bit ie = (t % 3) != 2;
      load(s, len);
      cap_n = 0; irq_n = 0; hold_err = 0;
      wr(base(s) + 12'h7FC, ie ? 32'h9 : 32'h1);
      wait_free(s, "R5 busy clears");
      chk(cap_n == len, "R5 byte count", cap_n, len);
      cmp_frame(s, 0, len, "R4 bytes/order/last");
      chk(irq_n == (ie ? 1 : 0), "R11 irq pulses", irq_n, ie ? 1 : 0);
      chk(hold_err == 0, "R7 data hold", hold_err, 0);
    end

    // R5 clamp to capacity
    load(0, CAP + 5);
    cap_n = 0; irq_n = 0;
    wr(12'h7FC, 32'h9);
    wait_free(0, "R5 clamp busy clears");
    chk(cap_n == CAP, "R5 clamp count", cap_n, CAP);
    cmp_frame(0, 0, CAP, "R5 clamp bytes");

    // R6 zero count
    wr(12'h7F4, 32'h0);
    cap_n = 0; irq_n = 0;
    wr(12'h7FC, 32'h9);
    wait_free(0, "R6 zero completes");
    chk(cap_n == 0, "R6 no bytes", cap_n, 0);
    chk(irq_n == 1, "R11 zero count irq", irq_n, 1);

    // R8 program command
    load(1, 6);
    cap_n = 0; irq_n = 0;
    wr(12'hFFC, 32'hB);
    wait_free(1, "R8 bits clear");
    chk(mac_addr == {fb[1][0], fb[1][1], fb[1][2], fb[1][3], fb[1][4], fb[1][5]},
        "R8 mac value", mac_addr,
        {fb[1][0], fb[1][1], fb[1][2], fb[1][3], fb[1][4], fb[1][5]});
    chk(cap_n == 0 && irq_n == 0, "R8 no bytes no irq", cap_n + irq_n, 0);

    // R9 abort, R10 launch order
    rdy_mode = 0;
    load(0, 40);
    load(1, 24);
    cap_n = 0; irq_n = 0;
    wr(12'h7FC, 32'h9);
    repeat (3) @(negedge clk);
    chk(tx_valid, "R9 ping offered", tx_valid, 1);
    wr(12'hFFC, 32'h9);
    wr(12'h7FC, 32'h8);
    rd(12'h7FC, v); chk(v == 32'h8, "R9 abort clears busy", v, 8);
    wr(12'h7FC, 32'h9);
    repeat (4) @(negedge clk);
    rdy_mode = 2;
    wait_free(1, "R10 pong done");
    wait_free(0, "R10 ping done");
    chk(cap_n == 64, "R10 total bytes", cap_n, 64);
    cmp_frame(1, 0, 24, "R10 pong first");
    cmp_frame(0, 24, 40, "R10 ping second");
    chk(irq_n == 2, "R9 R11 irq count", irq_n, 2);

    // R9 abort with no relaunch
    rdy_mode = 0;
    cap_n = 0; irq_n = 0;
    wr(12'h7FC, 32'h9);
    repeat (3) @(negedge clk);
    wr(12'h7FC, 32'h0);
    rdy_mode = 2;
    repeat (20) @(negedge clk);
    chk(cap_n == 0 && irq_n == 0 && !tx_valid, "R9 aborted silent", cap_n + irq_n, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule